// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence for a burst of four words out of an aligned group of four. It captures the starting address when an access begins, then steps through the group one word each time the advance input is high. The starting word can sit anywhere in the group. The sequence wraps inside the group, so it never crosses into a neighbouring group.

Two strobe inputs can open an access. Either one, or both together, loads the address bus into the sequencer and resets the beat index to zero. A static order input chooses how beats map to word offsets. In interleaved order the start offset is XORed with the beat. In linear order the beat is added to the start offset modulo four. The memory array takes the full burst address, and the surrounding control logic takes the beat index.

The asynchronous active-low reset is released through a two-stage synchronizer. The block therefore leaves reset on the second rising edge after the reset input rises.

Top module: `burst_seq`

## Requirements
- R1: While reset is active, and right after it is released, burst_addr and beat_idx are both zero.
- R2: A high strobe_cpu at a rising edge loads addr_in into the sequencer. After that edge, burst_addr equals addr_in and beat_idx is 0.
- R3: A high strobe_ctl at a rising edge loads the sequencer in the same way as R2. When both strobes are high, the load is the same as with either one alone.
- R4: When neither strobe is high, each edge with adv high adds one to beat_idx modulo 4. Each edge with adv low leaves beat_idx and burst_addr unchanged.
- R5: With order_sel = 1 (interleaved), burst_addr[1:0] equals the start offset XOR beat_idx. A start of 1 gives the order 1,0,3,2.
- R6: With order_sel = 0 (linear), burst_addr[1:0] equals (start offset + beat_idx) mod 4. A start of 1 gives the order 1,2,3,0.
- R7: burst_addr[ADDR_W-1:2] holds the captured upper address for the whole burst. After four advances, the low bits return to the start offset.
- R8: A strobe in the same cycle as adv takes priority. The sequencer reloads, and beat_idx becomes 0, not beat+1.
- R9: order_sel is not stored. burst_addr follows a change of order_sel in the same cycle, with no clock edge needed, while beat_idx stays as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_cpu | input | 1 | First access strobe; loads the start address |
| strobe_ctl | input | 1 | Second access strobe; loads the start address |
| adv | input | 1 | Step one beat at this edge |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Start address of an access |
| burst_addr | output | ADDR_W | Address of the current beat |
| beat_idx | output | 2 | Number of the current beat, 0 to 3 |

## Verification
A strobe and an advance can arrive at the same edge. This case decides whether a new access truly restarts the sequence. The bench opens a burst, advances it to a middle beat, and then raises a strobe with a new address while adv is still high. It expects beat 0 and the new start address, and it would see beat+1 or the old address if priority were reversed. A second same-cycle case raises both strobes together and expects a single clean load.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Word offset within the aligned group for a given start and beat
  function automatic logic [BEAT_W-1:0] offset_of(
    input order_e                ord,
    input logic [BEAT_W-1:0]     start,
    input logic [BEAT_W-1:0]     beat
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    else                       return start + beat;
  endfunction
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb shift_d = 1'b1;
    end else begin : g_many
      always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  always_comb begin
    beat_en = load | step;
    if (load) beat_d = '0;
    else      beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat = beat_q;

  p_load_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat_q == '0));
  p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat_q));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;

  always_comb base_d = addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_d;
  end

  assign base = base_q;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (base_q == $past(addr_in)));
  p_keep_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  order_e            ord,
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] low;

  always_comb low = offset_of(ord, base[BEAT_W-1:0], beat);

  generate
    if (UP_W > 0) begin : g_upper
      assign addr = {base[ADDR_W-1:BEAT_W], low};
    end else begin : g_low_only
      assign addr = low;
    end
  endgenerate

  always_comb begin
    if (beat == '0) begin
      p_first_beat_r5: assert (addr == base);
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [1:0]        beat_idx
);
  logic              rst_q_n;
  logic              load;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  order_e            ord;

  assign load = strobe_cpu | strobe_ctl;
  assign ord  = order_e'(order_sel);

  burst_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load    (load),
    .addr_in (addr_in),
    .base    (base)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_q_n),
    .load  (load),
    .step  (adv),
    .beat  (beat)
  );

  burst_order_map #(.ADDR_W(ADDR_W)) u_map (
    .ord  (ord),
    .base (base),
    .beat (beat),
    .addr (burst_addr)
  );

  assign beat_idx = beat;

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !load |=> (burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W])));
  p_reload_addr_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    load |=> (burst_addr == $past(addr_in)));
endmodule

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
  localparam int ADDR_W = 16;

  logic              clk;
  logic              rst_n;
  logic              strobe_cpu;
  logic              strobe_ctl;
  logic              adv;
  logic              order_sel;
  logic [ADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0] burst_addr;
  logic [1:0]        beat_idx;

  int n_chk;
  int n_fail;

  burst_seq #(.ADDR_W(ADDR_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .adv        (adv),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .burst_addr (burst_addr),
    .beat_idx   (beat_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [ADDR_W-1:0] expect_addr(
    input logic [ADDR_W-1:0] start, input int k, input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (start[1:0] ^ 2'(k)) : 2'(start[1:0] + 2'(k));
    return {start[ADDR_W-1:2], lo};
  endfunction

  task automatic open_burst(input logic which, input logic [ADDR_W-1:0] a);
    addr_in    = a;
    strobe_cpu = ~which;
    strobe_ctl = which;
    tick();
    strobe_cpu = 1'b0;
    strobe_ctl = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    strobe_cpu = 0; strobe_ctl = 0; adv = 0; order_sel = 0; addr_in = '0;
    repeat (3) tick();
    chk("R1 addr in reset", burst_addr, '0);
    chk("R1 beat in reset", 16'(beat_idx), '0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 addr after release", burst_addr, '0);
    chk("R1 beat after release", 16'(beat_idx), '0);
  endtask

  task automatic t_walk(input logic which, input logic ilv,
                        input logic [ADDR_W-1:0] a, input string req);
    order_sel = ilv;
    open_burst(which, a);
    chk({req, " load"}, burst_addr, a);
    chk({req, " beat0"}, 16'(beat_idx), '0);
    adv = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk({req, " order"}, burst_addr, expect_addr(a, k, ilv));
      chk({req, " beat"}, 16'(beat_idx), 16'(k % 4));
    end
    adv = 1'b0;
    chk("R7 wrap to start", burst_addr, a);
  endtask

  task automatic t_hold();
    order_sel = 1'b0;
    open_burst(1'b0, 16'h5A72);
    adv = 1'b1; tick(); adv = 1'b0;
    repeat (3) begin
      tick();
      chk("R4 hold addr", burst_addr, 16'h5A73);
      chk("R4 hold beat", 16'(beat_idx), 16'd1);
    end
  endtask

  task automatic t_priority();
    order_sel = 1'b1;
    open_burst(1'b1, 16'h0101);
    adv = 1'b1; tick(); tick();
    chk("R8 mid burst", burst_addr, expect_addr(16'h0101, 2, 1'b1));
    addr_in = 16'hBEE2; strobe_cpu = 1'b1;
    tick();
    strobe_cpu = 1'b0;
    chk("R8 reload wins addr", burst_addr, 16'hBEE2);
    chk("R8 reload wins beat", 16'(beat_idx), '0);
    tick();
    chk("R8 continues", burst_addr, 16'hBEE3);
    adv = 1'b0;
    addr_in = 16'h7777; strobe_cpu = 1'b1; strobe_ctl = 1'b1;
    tick();
    strobe_cpu = 1'b0; strobe_ctl = 1'b0;
    chk("R3 both strobes addr", burst_addr, 16'h7777);
    chk("R3 both strobes beat", 16'(beat_idx), '0);
  endtask

  task automatic t_mode_switch();
    order_sel = 1'b1;
    open_burst(1'b0, 16'h3331);
    adv = 1'b1; tick(); adv = 1'b0;
    chk("R9 interleaved beat1", burst_addr, 16'h3330);
    order_sel = 1'b0;
    #1;
    chk("R9 linear same cycle", burst_addr, 16'h3332);
    chk("R9 beat kept", 16'(beat_idx), 16'd1);
  endtask

  task automatic t_all_starts();
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        t_walk(m[0], m[0], 16'hC0C0 | 16'(s), m[0] ? "R5 sweep" : "R6 sweep");
      end
    end
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    t_reset();
    t_walk(1'b0, 1'b1, 16'h1235, "R5 R2 interleave");
    t_walk(1'b1, 1'b0, 16'hA0F1, "R6 R3 linear");
    t_hold();
    t_priority();
    t_mode_switch();
    t_all_starts();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule